// File: doc/BRIEF.md
# Macroblock Residual Block Scheduler

This block walks through the 4x4 residual blocks of one macroblock. For each block, or each horizontal pair of blocks, it picks one of three outcomes: leave the block alone, send it downstream for a full inverse transform, or apply a DC-only correction itself. The choice depends on a table of per-block nonzero-coefficient counts and on the DC coefficients of the blocks. A `start` pulse selects one of three schedules: inter luma, intra luma or chroma. A command for a full transform carries the block index, the action code, the destination pixel address and the coefficient address. The command leaves over a valid/ready handshake to a reconstruction unit outside this block.

For a DC-only pair the block does the whole correction on its own. It computes the rounded DC delta and reads each of the four pixel rows of the 4x4 block. It adds the delta to each row, clips the result and writes the row back. It then clears that block's DC coefficient and issues an informational command that carries the DC-only action code. The full transform engine and the arbitration of memory ports sit outside the block.

Top module: `resid_blk_sched`

## Requirements
- R1: With `sched_sel`=2'b00 (inter luma), the 16 luma blocks are visited in index order 0..15. Block k reads its count byte at table slot row*8+col, where col = 4 + k[0] + 2*k[2] and row = 1 + k[1] + 2*k[3]. A zero byte skips the block. A nonzero byte issues one command with action 2'b01 (full).
- R2: Count slot i sits at `cnt_table[i*8 +: 8]` and the offset of block b sits at `off_table[b*16 +: 16]`. A command carries `cmd_addr` = plane base + offset of `cmd_blk`, and `cmd_coef` = 16*`cmd_blk`. The plane base is `base_b` for blocks 32 and above, and `base_a` for all others.
- R3: With `sched_sel`=2'b01 (intra luma), the pairs (k, k+1) for k = 0, 2, ..., 14 are visited in order. Each pair reads the slots of k and k+1. If either byte is nonzero, the block issues full commands for k and then for k+1.
- R4: When both count bytes of a pair are zero but either DC value is nonzero, both blocks take the DC-only path. For block k and then for block k+1, the block updates the pixel rows and then issues a command with action 2'b10.
- R5: A DC-only update computes delta = (dc + 32) >>> 6, an arithmetic shift. For rows r = 0..3, it reads the 4-pixel word at block address + r*`stride`, then one cycle later writes each pixel + delta, clipped to 0..1023, back to the same address. Pixel j of a word sits at bits [j*10 +: 10].
- R6: `dc_clr_en` pulses with `dc_clr_idx` equal to the block's index in the same cycle as the block's fourth row write.
- R7: A pair whose counts and DC values are all zero produces no command, no pixel access and no DC clear.
- R8: With `sched_sel`=2'b10 (chroma), the pairs starting at blocks 16, 18, 32 and 34 are visited in that order. They use count slots in column 4 (and column 5 for the second block of the pair) of rows 6, 7, 11 and 12, and they follow the R3/R4/R7 rules.
- R9: Only one command is outstanding at a time. While `cmd_valid` is high and `cmd_ready` is low, the command fields hold steady. Action 2'b00 never appears on a valid command.
- R10: `busy` rises the cycle after an accepted `start`. `done` pulses for one cycle after the last item has been accepted or skipped, and `busy` is low in the cycle after that. A `start` that arrives while `busy` is high is ignored.
- R11: After reset, `busy`, `done`, `cmd_valid`, `pix_rd_en`, `pix_wr_en` and `dc_clr_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a schedule (ignored while busy) |
| sched_sel | input | 2 | 00 inter luma, 01 intra luma, 10 chroma |
| stride | input | 16 | Word distance between pixel rows |
| base_a | input | 16 | Destination base for luma and first chroma plane |
| base_b | input | 16 | Destination base for second chroma plane |
| cnt_table | input | 960 | 120 count bytes, slot i at [i*8 +: 8] |
| off_table | input | 768 | 48 block offsets, block b at [b*16 +: 16] |
| dc_idx_a | output | 6 | Block index whose DC is read on dc_val_a |
| dc_idx_b | output | 6 | Block index whose DC is read on dc_val_b |
| dc_val_a | input | 32 | DC coefficient of dc_idx_a (same cycle) |
| dc_val_b | input | 32 | DC coefficient of dc_idx_b (same cycle) |
| dc_clr_en | output | 1 | Clear the DC coefficient of dc_clr_idx |
| dc_clr_idx | output | 6 | Block whose DC is cleared |
| pix_rd_en | output | 1 | Pixel row read request |
| pix_rd_addr | output | 16 | Pixel row read address |
| pix_rd_data | input | 40 | Row data, one cycle after the request |
| pix_wr_en | output | 1 | Pixel row write |
| pix_wr_addr | output | 16 | Pixel row write address |
| pix_wr_data | output | 40 | Corrected, clipped row |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_blk | output | 6 | Block index |
| cmd_mode | output | 2 | 01 full transform, 10 DC-only |
| cmd_addr | output | 16 | Destination pixel address of the block |
| cmd_coef | output | 10 | Coefficient address of the block |
| busy | output | 1 | Schedule in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
On the cycle that writes the fourth pixel row of a DC-only block, the pixel write-back and the DC coefficient clear fall together. If one of them is late or missing, the coefficient store and the picture disagree. The bench drives DC-only pairs with small, negative, strongly negative and strongly positive DC values, so that the write-backs also cover the rounding and both clip limits. A scoreboard predicts every row write, every clear and every command in order. The monitor checks that each clear coincides with a write, and it compares the written words against a shadow picture.

// File: rtl/rbs_pkg.sv
// rbs_pkg: shared encodings for the residual block scheduler.
// Assumes: schedule select and action codes are fixed at two bits.
package rbs_pkg;

    // Which schedule a start pulse selects.
    typedef enum logic [1:0] {
        SCH_INTER  = 2'b00,
        SCH_INTRA  = 2'b01,
        SCH_CHROMA = 2'b10
    } sched_e;

    // What is done with a block; ACT_SKIP is never issued.
    typedef enum logic [1:0] {
        ACT_SKIP = 2'b00,
        ACT_FULL = 2'b01,
        ACT_DC   = 2'b10
    } act_e;

    // Controller states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_EVAL  = 3'd1,
        ST_RD    = 3'd2,
        ST_WR    = 3'd3,
        ST_ISSUE = 3'd4,
        ST_FIN   = 3'd5
    } state_e;

endpackage

// File: rtl/rbs_step_map.sv
// rbs_step_map: translates a schedule step into the first block index,
// the count-table slot of that block, whether the step covers a pair,
// and whether it is the final step of the selected schedule.
// Assumes: luma quadrant layout in columns 4..7 and rows 1..4 of the
// count table; chroma pairs sit in column 4 of rows 6, 7, 11 and 12.
module rbs_step_map
    import rbs_pkg::*;
#(
    parameter int CNT_COLS = 8,
    parameter int BLK_W    = 6,
    parameter int CIDX_W   = 7,
    parameter int STEP_W   = 4
) (
    input  logic [1:0]        sel,
    input  logic [STEP_W-1:0] step,
    output logic [BLK_W-1:0]  blk,
    output logic [CIDX_W-1:0] cidx,
    output logic              pair,
    output logic              last
);
    localparam int LUMA_COL0 = 4;
    localparam int LUMA_ROW0 = 1;
    localparam int CHR_COL   = 4;
    localparam int CHR_ROW0  = 6;
    localparam int CHR_PLANE_ROWS = 5;
    localparam int CHR_BLK0  = 16;
    localparam int CHR_PLANE_BLKS = 16;

    logic [3:0] k;
    int         row;
    int         col;

    // Compute block index and table slot for the current step.
    always_comb begin
        k    = '0;
        row  = 0;
        col  = 0;
        blk  = '0;
        pair = 1'b0;
        last = 1'b0;
        case (sel)
            SCH_INTRA: begin
                k    = {step[2:0], 1'b0};
                row  = LUMA_ROW0 + int'(k[1]) + 2 * int'(k[3]);
                col  = LUMA_COL0 + int'(k[0]) + 2 * int'(k[2]);
                blk  = BLK_W'(k);
                pair = 1'b1;
                last = (step == STEP_W'(7));
            end
            SCH_CHROMA: begin
                row  = CHR_ROW0 + int'(step[0]) + CHR_PLANE_ROWS * int'(step[1]);
                col  = CHR_COL;
                blk  = BLK_W'(CHR_BLK0 + 2 * int'(step[0]) + CHR_PLANE_BLKS * int'(step[1]));
                pair = 1'b1;
                last = (step == STEP_W'(3));
            end
            default: begin
                k    = step[3:0];
                row  = LUMA_ROW0 + int'(k[1]) + 2 * int'(k[3]);
                col  = LUMA_COL0 + int'(k[0]) + 2 * int'(k[2]);
                blk  = BLK_W'(k);
                pair = 1'b0;
                last = (step == STEP_W'(15));
            end
        endcase
        cidx = CIDX_W'(row * CNT_COLS + col);
    end

endmodule

// File: rtl/rbs_decide.sv
// rbs_decide: picks skip / full / DC-only for a single block or a pair.
// Assumes: for a single (inter) block only cnt_a matters; for a pair any
// nonzero count forces full, else any nonzero DC forces DC-only.
module rbs_decide
    import rbs_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int COEF_W = 32
) (
    input  logic              pair,
    input  logic [CNT_W-1:0]  cnt_a,
    input  logic [CNT_W-1:0]  cnt_b,
    input  logic [COEF_W-1:0] dc_a,
    input  logic [COEF_W-1:0] dc_b,
    output act_e              act
);
    // Three-way decision with count priority over DC.
    always_comb begin
        if (!pair) begin
            act = (cnt_a != '0) ? ACT_FULL : ACT_SKIP;
        end else if ((cnt_a != '0) || (cnt_b != '0)) begin
            act = ACT_FULL;
        end else if ((dc_a != '0) || (dc_b != '0)) begin
            act = ACT_DC;
        end else begin
            act = ACT_SKIP;
        end
    end

endmodule

// File: rtl/rbs_dc_add.sv
// rbs_dc_add: rounds a DC coefficient to a pixel delta and applies it,
// with clipping, to every pixel lane of one row word.
// Assumes: pixels are unsigned PIX_W bits; dc is signed COEF_W bits.
module rbs_dc_add #(
    parameter int PIX_W  = 10,
    parameter int COEF_W = 32,
    parameter int LANES  = 4
) (
    input  logic [COEF_W-1:0]      dc,
    input  logic [LANES*PIX_W-1:0] row_in,
    output logic [LANES*PIX_W-1:0] row_out
);
    localparam int SUM_W = COEF_W + 2;
    localparam int RND   = 32;
    localparam int SHIFT = 6;
    localparam logic signed [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

    logic signed [SUM_W-1:0] delta;

    // Rounded, arithmetically shifted DC delta.
    always_comb begin
        delta = ($signed({{2{dc[COEF_W-1]}}, dc}) + SUM_W'(RND)) >>> SHIFT;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic signed [SUM_W-1:0] sum;
        // Add delta to one pixel and clamp into the pixel range.
        always_comb begin
            sum = delta + $signed({{(SUM_W-PIX_W){1'b0}}, row_in[j*PIX_W +: PIX_W]});
            if (sum < 0) begin
                row_out[j*PIX_W +: PIX_W] = '0;
            end else if (sum > PIX_MAX) begin
                row_out[j*PIX_W +: PIX_W] = PIX_MAX[PIX_W-1:0];
            end else begin
                row_out[j*PIX_W +: PIX_W] = sum[PIX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/resid_blk_sched.sv
// resid_blk_sched: walks the residual blocks of a macroblock for the
// selected schedule, issues full-transform and DC-only commands one at a
// time, and performs DC-only pixel updates through a row-wide pixel port.
// Assumes: dc_val_a/b follow dc_idx_a/b in the same cycle; pixel reads
// return data one cycle after pix_rd_en; blocks are LANES rows high.
module resid_blk_sched
    import rbs_pkg::*;
#(
    parameter int CNT_ROWS     = 15,
    parameter int CNT_COLS     = 8,
    parameter int CNT_W        = 8,
    parameter int BLK_SLOTS    = 48,
    parameter int ADDR_W       = 16,
    parameter int COEF_W       = 32,
    parameter int PIX_W        = 10,
    parameter int LANES        = 4,
    parameter int PLANE2_BLK   = 32,
    parameter int COEF_PER_BLK = 16,
    localparam int BLK_W   = $clog2(BLK_SLOTS),
    localparam int CIDX_W  = $clog2(CNT_ROWS * CNT_COLS),
    localparam int COEF_AW = $clog2(BLK_SLOTS * COEF_PER_BLK),
    localparam int ROW_BITS = LANES * PIX_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic [1:0]                       sched_sel,
    input  logic [ADDR_W-1:0]                stride,
    input  logic [ADDR_W-1:0]                base_a,
    input  logic [ADDR_W-1:0]                base_b,
    input  logic [CNT_ROWS*CNT_COLS*CNT_W-1:0] cnt_table,
    input  logic [BLK_SLOTS*ADDR_W-1:0]      off_table,
    output logic [BLK_W-1:0]                 dc_idx_a,
    output logic [BLK_W-1:0]                 dc_idx_b,
    input  logic [COEF_W-1:0]                dc_val_a,
    input  logic [COEF_W-1:0]                dc_val_b,
    output logic                             dc_clr_en,
    output logic [BLK_W-1:0]                 dc_clr_idx,
    output logic                             pix_rd_en,
    output logic [ADDR_W-1:0]                pix_rd_addr,
    input  logic [ROW_BITS-1:0]              pix_rd_data,
    output logic                             pix_wr_en,
    output logic [ADDR_W-1:0]                pix_wr_addr,
    output logic [ROW_BITS-1:0]              pix_wr_data,
    output logic                             cmd_valid,
    input  logic                             cmd_ready,
    output logic [BLK_W-1:0]                 cmd_blk,
    output logic [1:0]                       cmd_mode,
    output logic [ADDR_W-1:0]                cmd_addr,
    output logic [COEF_AW-1:0]               cmd_coef,
    output logic                             busy,
    output logic                             done
);
    localparam int STEP_W   = 4;
    localparam int ROW_W    = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(LANES - 1);

    state_e              state_q;
    logic [1:0]          sel_q;
    logic [STEP_W-1:0]   step_q;
    logic [BLK_W-1:0]    cur_blk_q;
    act_e                act_q;
    logic                second_q;
    logic [ROW_W-1:0]    row_q;
    logic [COEF_W-1:0]   dc_a_q;
    logic [COEF_W-1:0]   dc_b_q;
    logic                use_b_q;

    logic [BLK_W-1:0]    sm_blk;
    logic [CIDX_W-1:0]   sm_cidx;
    logic                sm_pair;
    logic                sm_last;
    logic [CNT_W-1:0]    cnt_a;
    logic [CNT_W-1:0]    cnt_b;
    act_e                dec_act;
    logic [ADDR_W-1:0]   plane_base;
    logic [ADDR_W-1:0]   blk_addr;
    logic [ADDR_W-1:0]   row_addr;
    logic [COEF_W-1:0]   dc_cur;

    // Step-to-block translation for the latched schedule.
    rbs_step_map #(
        .CNT_COLS(CNT_COLS),
        .BLK_W   (BLK_W),
        .CIDX_W  (CIDX_W),
        .STEP_W  (STEP_W)
    ) u_map (
        .sel (sel_q),
        .step(step_q),
        .blk (sm_blk),
        .cidx(sm_cidx),
        .pair(sm_pair),
        .last(sm_last)
    );

    // Fetch the two adjacent count bytes for the current step.
    always_comb begin
        cnt_a = cnt_table[int'(sm_cidx) * CNT_W +: CNT_W];
        cnt_b = cnt_table[(int'(sm_cidx) + 1) * CNT_W +: CNT_W];
    end

    assign dc_idx_a = sm_blk;
    assign dc_idx_b = sm_blk + BLK_W'(1);

    // Skip / full / DC-only decision.
    rbs_decide #(
        .CNT_W (CNT_W),
        .COEF_W(COEF_W)
    ) u_dec (
        .pair (sm_pair),
        .cnt_a(cnt_a),
        .cnt_b(cnt_b),
        .dc_a (dc_val_a),
        .dc_b (dc_val_b),
        .act  (dec_act)
    );

    // Destination address of the current block and of the current row.
    always_comb begin
        plane_base = (int'(cur_blk_q) >= PLANE2_BLK) ? base_b : base_a;
        blk_addr   = plane_base + off_table[int'(cur_blk_q) * ADDR_W +: ADDR_W];
        row_addr   = blk_addr + ADDR_W'(row_q) * stride;
        dc_cur     = use_b_q ? dc_b_q : dc_a_q;
    end

    // DC-only row correction.
    rbs_dc_add #(
        .PIX_W (PIX_W),
        .COEF_W(COEF_W),
        .LANES (LANES)
    ) u_dc (
        .dc     (dc_cur),
        .row_in (pix_rd_data),
        .row_out(pix_wr_data)
    );

    // Schedule controller: evaluate, update rows, issue, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            sel_q     <= SCH_INTER;
            step_q    <= '0;
            cur_blk_q <= '0;
            act_q     <= ACT_SKIP;
            second_q  <= 1'b0;
            row_q     <= '0;
            dc_a_q    <= '0;
            dc_b_q    <= '0;
            use_b_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        sel_q   <= sched_sel;
                        step_q  <= '0;
                        state_q <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    case (dec_act)
                        ACT_FULL: begin
                            cur_blk_q <= sm_blk;
                            act_q     <= ACT_FULL;
                            second_q  <= sm_pair;
                            state_q   <= ST_ISSUE;
                        end
                        ACT_DC: begin
                            cur_blk_q <= sm_blk;
                            act_q     <= ACT_DC;
                            second_q  <= 1'b1;
                            dc_a_q    <= dc_val_a;
                            dc_b_q    <= dc_val_b;
                            use_b_q   <= 1'b0;
                            row_q     <= '0;
                            state_q   <= ST_RD;
                        end
                        default: begin
                            if (sm_last) begin
                                state_q <= ST_FIN;
                            end else begin
                                step_q  <= step_q + STEP_W'(1);
                                state_q <= ST_EVAL;
                            end
                        end
                    endcase
                end
                ST_RD: begin
                    state_q <= ST_WR;
                end
                ST_WR: begin
                    if (row_q == LAST_ROW) begin
                        state_q <= ST_ISSUE;
                    end else begin
                        row_q   <= row_q + ROW_W'(1);
                        state_q <= ST_RD;
                    end
                end
                ST_ISSUE: begin
                    if (cmd_ready) begin
                        if (second_q) begin
                            second_q  <= 1'b0;
                            cur_blk_q <= cur_blk_q + BLK_W'(1);
                            if (act_q == ACT_DC) begin
                                use_b_q <= 1'b1;
                                row_q   <= '0;
                                state_q <= ST_RD;
                            end
                        end else if (sm_last) begin
                            state_q <= ST_FIN;
                        end else begin
                            step_q  <= step_q + STEP_W'(1);
                            state_q <= ST_EVAL;
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Port outputs decoded from state.
    always_comb begin
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_FIN);
        pix_rd_en   = (state_q == ST_RD);
        pix_wr_en   = (state_q == ST_WR);
        pix_rd_addr = row_addr;
        pix_wr_addr = row_addr;
        dc_clr_en   = (state_q == ST_WR) && (row_q == LAST_ROW);
        dc_clr_idx  = cur_blk_q;
        cmd_valid   = (state_q == ST_ISSUE);
        cmd_blk     = cur_blk_q;
        cmd_mode    = act_q;
        cmd_addr    = blk_addr;
        cmd_coef    = COEF_AW'(int'(cur_blk_q) * COEF_PER_BLK);
    end

endmodule

// File: rtl/rbs_checker.sv
// rbs_checker: protocol and sequencing properties of resid_blk_sched,
// attached with bind. Assumes the same width parameters as the top.
module rbs_checker #(
    parameter int BLK_W  = 6,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [BLK_W-1:0]  cmd_blk,
    input logic [1:0]        cmd_mode,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              pix_rd_en,
    input logic              pix_wr_en,
    input logic              dc_clr_en
);
    // R9: a stalled command keeps its fields.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_blk)
            && $stable(cmd_mode) && $stable(cmd_addr));

    // R9: a skip code never appears on a valid command.
    a_r9_mode: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_mode == 2'b01 || cmd_mode == 2'b10));

    // R9: command, row read and row write are mutually exclusive.
    a_r9_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, pix_rd_en, pix_wr_en}));

    // R6: the DC clear lands together with a row write.
    a_r6_clr_with_wr: assert property (@(posedge clk) disable iff (!rst_n)
        dc_clr_en |-> pix_wr_en);

    // R5: each row write follows a row read in the previous cycle.
    a_r5_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        pix_wr_en |-> $past(pix_rd_en));

    // R10: done is a single cycle and busy drops after it.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R10: an accepted start raises busy.
    a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    // R11: nothing is issued while idle.
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid && !pix_rd_en && !pix_wr_en);

endmodule

bind resid_blk_sched rbs_checker #(
    .BLK_W (BLK_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_blk  (cmd_blk),
    .cmd_mode (cmd_mode),
    .cmd_addr (cmd_addr),
    .pix_rd_en(pix_rd_en),
    .pix_wr_en(pix_wr_en),
    .dc_clr_en(dc_clr_en)
);

// File: tb/resid_blk_sched_test.sv
// Scoreboard bench: run tasks predict commands, row writes and DC clears
// into queues; a negedge monitor pops and compares them.
module resid_blk_sched_test;
    localparam logic [15:0] BASE_A = 16'd100;
    localparam logic [15:0] BASE_B = 16'd2500;
    localparam logic [15:0] STRIDE = 16'd8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, start, cmd_ready;
    logic [1:0]    sched_sel;
    logic [959:0]  cnt_table;
    logic [767:0]  off_table;
    logic [5:0]    dc_idx_a, dc_idx_b, dc_clr_idx, cmd_blk;
    logic [31:0]   dc_val_a, dc_val_b;
    logic          dc_clr_en, pix_rd_en, pix_wr_en, cmd_valid, busy, done;
    logic [15:0]   pix_rd_addr, pix_wr_addr, cmd_addr;
    logic [39:0]   pix_rd_data, pix_wr_data;
    logic [1:0]    cmd_mode;
    logic [9:0]    cmd_coef;

    resid_blk_sched uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sched_sel(sched_sel),
        .stride(STRIDE), .base_a(BASE_A), .base_b(BASE_B),
        .cnt_table(cnt_table), .off_table(off_table),
        .dc_idx_a(dc_idx_a), .dc_idx_b(dc_idx_b),
        .dc_val_a(dc_val_a), .dc_val_b(dc_val_b),
        .dc_clr_en(dc_clr_en), .dc_clr_idx(dc_clr_idx),
        .pix_rd_en(pix_rd_en), .pix_rd_addr(pix_rd_addr), .pix_rd_data(pix_rd_data),
        .pix_wr_en(pix_wr_en), .pix_wr_addr(pix_wr_addr), .pix_wr_data(pix_wr_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_blk(cmd_blk),
        .cmd_mode(cmd_mode), .cmd_addr(cmd_addr), .cmd_coef(cmd_coef),
        .busy(busy), .done(done)
    );

    typedef struct packed {
        logic [7:0]  tag;
        logic [5:0]  blk;
        logic [1:0]  mode;
        logic [15:0] addr;
        logic [9:0]  coef;
    } exp_cmd_t;
    typedef struct packed {
        logic [15:0] addr;
        logic [39:0] data;
    } exp_pix_t;

    exp_cmd_t    cmd_q[$];
    exp_pix_t    pix_q[$];
    logic [5:0]  clr_q[$];

    logic [7:0]         cnt_tab [0:119];
    logic [15:0]        off_tab [0:47];
    logic signed [31:0] dc_mem  [0:63];
    logic signed [31:0] exp_dc  [0:63];
    logic [39:0]        mem     [0:4095];
    logic [39:0]        exp_mem [0:4095];
    logic [39:0]        rd_q;
    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit stall    = 1'b0;

    always_comb begin
        for (int i = 0; i < 120; i++) cnt_table[i*8 +: 8] = cnt_tab[i];
        for (int i = 0; i < 48; i++)  off_table[i*16 +: 16] = off_tab[i];
    end
    assign dc_val_a    = dc_mem[dc_idx_a];
    assign dc_val_b    = dc_mem[dc_idx_b];
    assign pix_rd_data = rd_q;

    // Memory, DC store and ready models.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (pix_rd_en) rd_q <= mem[pix_rd_addr[11:0]];
        if (pix_wr_en) mem[pix_wr_addr[11:0]] <= pix_wr_data;
        if (dc_clr_en) dc_mem[dc_clr_idx] <= 32'sd0;
    end
    always begin
        @(posedge clk);
        #2;
        cmd_ready = stall ? ((cyc % 3) == 0) : 1'b1;
    end

    function automatic string tname(input logic [7:0] t);
        case (t)
            1: return "R1";
            3: return "R3";
            4: return "R4";
            8: return "R8";
            9: return "R9";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: compare every observed event against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid && cmd_ready) begin
                if (cmd_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected command blk", longint'(cmd_blk), -1);
                end else begin
                    exp_cmd_t e;
                    e = cmd_q.pop_front();
                    chk(cmd_blk == e.blk, tname(e.tag), "cmd blk", cmd_blk, e.blk);
                    chk(cmd_mode == e.mode, tname(e.tag), "cmd mode", cmd_mode, e.mode);
                    chk(cmd_addr == e.addr, "R2", "cmd addr", cmd_addr, e.addr);
                    chk(cmd_coef == e.coef, "R2", "cmd coef", cmd_coef, e.coef);
                end
            end
            if (pix_wr_en) begin
                if (pix_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected row write addr", longint'(pix_wr_addr), -1);
                end else begin
                    exp_pix_t p;
                    p = pix_q.pop_front();
                    chk(pix_wr_addr == p.addr, "R5", "row write addr", pix_wr_addr, p.addr);
                    chk(pix_wr_data == p.data, "R5", "row write data", longint'(pix_wr_data), longint'(p.data));
                end
            end
            if (dc_clr_en) begin
                if (clr_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected DC clear idx", longint'(dc_clr_idx), -1);
                end else begin
                    logic [5:0] ci;
                    ci = clr_q.pop_front();
                    chk(dc_clr_idx == ci, "R6", "DC clear idx", dc_clr_idx, ci);
                    chk(pix_wr_en == 1'b1, "R6", "clear with row write", pix_wr_en, 1);
                end
            end
        end
    end

    function automatic int lmap(input int k);
        return (1 + ((k >> 1) & 1) + 2 * ((k >> 3) & 1)) * 8
             + 4 + (k & 1) + 2 * ((k >> 2) & 1);
    endfunction

    task automatic push_cmd(input int tag, input int b, input logic [1:0] mode);
        exp_cmd_t e;
        e.tag  = 8'(tag);
        e.blk  = 6'(b);
        e.mode = mode;
        e.addr = ((b >= 32) ? BASE_B : BASE_A) + off_tab[b];
        e.coef = 10'(b * 16);
        cmd_q.push_back(e);
    endtask

    task automatic push_dc_block(input int b);
        longint d;
        logic [15:0] a0;
        d  = (longint'(exp_dc[b]) + 32) >>> 6;
        a0 = ((b >= 32) ? BASE_B : BASE_A) + off_tab[b];
        for (int r = 0; r < 4; r++) begin
            exp_pix_t p;
            logic [15:0] a;
            logic [39:0] w;
            a = a0 + 16'(r) * STRIDE;
            w = exp_mem[a[11:0]];
            for (int j = 0; j < 4; j++) begin
                longint s;
                s = longint'(w[j*10 +: 10]) + d;
                if (s < 0) s = 0;
                if (s > 1023) s = 1023;
                w[j*10 +: 10] = 10'(s);
            end
            exp_mem[a[11:0]] = w;
            p.addr = a;
            p.data = w;
            pix_q.push_back(p);
        end
        clr_q.push_back(6'(b));
        exp_dc[b] = 32'sd0;
        push_cmd(4, b, 2'b10);
    endtask

    task automatic do_pair(input int k, input int idx, input int tag);
        if (cnt_tab[idx] != 0 || cnt_tab[idx+1] != 0) begin
            push_cmd(tag, k, 2'b01);
            push_cmd(tag, k + 1, 2'b01);
        end else if (exp_dc[k] != 0 || exp_dc[k+1] != 0) begin
            push_dc_block(k);
            push_dc_block(k + 1);
        end
    endtask

    task automatic set_dc(input int b, input logic signed [31:0] v);
        dc_mem[b] = v;
        exp_dc[b] = v;
    endtask

    task automatic clear_tables();
        for (int i = 0; i < 120; i++) cnt_tab[i] = 8'd0;
        for (int i = 0; i < 64; i++) set_dc(i, 32'sd0);
    endtask

    // Driver: predict the run, start it, wait for completion.
    task automatic run(input logic [1:0] sel, input bit stl, input bit poke, input int tag);
        stall = stl;
        if (sel == 2'b00) begin
            for (int k = 0; k < 16; k++)
                if (cnt_tab[lmap(k)] != 0) push_cmd(tag, k, 2'b01);
        end else if (sel == 2'b01) begin
            for (int p = 0; p < 8; p++) do_pair(2 * p, lmap(2 * p), tag);
        end else begin
            for (int p = 0; p < 4; p++)
                do_pair(16 + 2 * (p % 2) + 16 * (p / 2), (6 + (p % 2) + 5 * (p / 2)) * 8 + 4, tag);
        end
        sched_sel = sel;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after start", busy, 1);
        if (poke) begin
            repeat (4) @(negedge clk);
            sched_sel = 2'b00;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(cmd_q.size() == 0, "R7", "commands left", cmd_q.size(), 0);
        chk(pix_q.size() == 0, "R7", "row writes left", pix_q.size(), 0);
        chk(clr_q.size() == 0, "R6", "clears left", clr_q.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done width", done, 0);
        chk(busy == 1'b0, "R10", "busy after done", busy, 0);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && cmd_valid == 1'b0, "R10", "no restart from ignored start", busy, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog: actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        sched_sel = 2'b00;
        cmd_ready = 1'b1;
        rd_q = '0;
        for (int a = 0; a < 4096; a++) begin
            logic [39:0] w;
            for (int j = 0; j < 4; j++) w[j*10 +: 10] = 10'((a * 37 + j * 101) % 1024);
            mem[a] = w;
            exp_mem[a] = w;
        end
        for (int b = 0; b < 48; b++) off_tab[b] = 16'(b * 40);
        clear_tables();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state.
        chk(busy == 0 && done == 0, "R11", "busy/done after reset", {busy, done}, 0);
        chk(cmd_valid == 0 && dc_clr_en == 0, "R11", "cmd/clear after reset", {cmd_valid, dc_clr_en}, 0);
        chk(pix_rd_en == 0 && pix_wr_en == 0, "R11", "pixel port after reset", {pix_rd_en, pix_wr_en}, 0);

        // R1: inter luma, sparse counts, ready always high.
        foreach (cnt_tab[i]) cnt_tab[i] = 8'd0;
        cnt_tab[lmap(0)] = 8'd1;  cnt_tab[lmap(3)] = 8'd4;
        cnt_tab[lmap(5)] = 8'd2;  cnt_tab[lmap(6)] = 8'd9;
        cnt_tab[lmap(9)] = 8'd1;  cnt_tab[lmap(12)] = 8'd16;
        cnt_tab[lmap(15)] = 8'd3;
        run(2'b00, 1'b0, 1'b0, 1);
        // R9: same schedule, different counts, with ready stalls.
        foreach (cnt_tab[i]) cnt_tab[i] = 8'd0;
        for (int k = 0; k < 16; k++) if (k % 3 != 1) cnt_tab[lmap(k)] = 8'(k + 1);
        run(2'b00, 1'b1, 1'b0, 9);

        // R3 / R4 / R5 / R7: intra luma pairs.
        clear_tables();
        cnt_tab[lmap(1)] = 8'd2;                 // pair 0: full
        set_dc(2, 32'sd100);                     // pair 2: DC, delta 2
        set_dc(5, -32'sd70000);                  // pair 4: DC, clip low
        set_dc(8, 32'sd70000);                   // pair 8: DC, clip high
        set_dc(9, -32'sd31);                     //         delta 0
        cnt_tab[lmap(10)] = 8'd1;                // pair 10: full despite DC
        set_dc(10, 32'sd500);
        set_dc(15, -32'sd33);                    // pair 14: DC, delta -1
        run(2'b01, 1'b1, 1'b0, 3);
        chk(dc_mem[10] == 32'sd500, "R3", "full pair leaves DC", dc_mem[10], 500);
        chk(dc_mem[8] == 32'sd0, "R6", "DC cleared in store", dc_mem[8], 0);

        // R7: all-zero intra schedule issues nothing but still completes.
        clear_tables();
        run(2'b01, 1'b0, 1'b0, 3);

        // R8: chroma with a start pulse mid-run (R10: ignored).
        clear_tables();
        cnt_tab[6*8 + 5] = 8'd3;                 // pair 16: full
        set_dc(18, 32'sd500);                    // pair 18: DC
        set_dc(35, -32'sd100);                   // pair 34: DC, delta -2, base_b
        run(2'b10, 1'b1, 1'b1, 8);
        clear_tables();
        cnt_tab[11*8 + 4] = 8'd1;                // pair 32: full on base_b
        set_dc(19, 32'sd64);                     // pair 18: DC
        run(2'b10, 1'b0, 1'b0, 8);

        summary();
        $finish;
    end

endmodule